// File: doc/BRIEF.md
# Programmable-Order Fractional Divide Shaper

This block produces, once per phase-detector clock, the integer division value for the feedback divider of a fractional-N synthesizer. Over many cycles the values it emits average to an integer part plus a fraction NUM/DEN. The modulus DEN is any 22-bit value from 2 upward and need not be a power of two, so channel spacings that do not divide the reference by a power of two are reached exactly.

The engine is a cascade of first-order accumulators that wrap at the programmed modulus. Their carries pass through difference networks whose depth matches a run-time order choice of integer, second, third or fourth. A pseudo-random dither bit can be added to the first accumulator to break up the periodic patterns that cause spurious tones. A single load strobe takes in a new configuration and restarts all modulator state at once. The output feeds a multi-modulus prescaler divider, so the integer part is expected to sit well above the largest negative excursion. If it does not, the output is held at zero rather than wrapping.

Top module: `fracn_shaper`

## Requirements
- R1: While `rst` is high, and on every clock after reset until the first load, `div_out` is 0 and the block is in integer mode.
- R2: A clock edge with `load` high latches `int_in`, `num_in`, `den_in` and `order_in`, clears every accumulator and difference-network history bit, and sets `div_out` to `int_in` at that edge.
- R3: Order code 0 on `order_in` selects integer mode. In this mode `div_out` equals the latched integer part every cycle, whatever the numerator and dither are.
- R4: Each stage adds its input to its residue. When the sum is at or above DEN it subtracts DEN and raises a carry. Stage 1 takes NUM (plus dither), and each later stage takes the new residue of the stage before, within the same cycle. Residues stay below DEN.
- R5: Order codes 1, 2 and 3 enable 2, 3 and 4 stages. The offset is the sum over enabled stages k (k = 1..order) of (1 - z^-1)^(k-1) applied to carry k, giving offsets in -(2^(order-1)-1) .. 2^(order-1). The registered output is the latched integer plus this offset, one cycle after the inputs that produced it.
- R6: With dither off, the sum of (`div_out` - integer) over the N cycles after a load differs from floor(N*NUM/DEN) by at most [0,1], [-1,2] or [-3,4] for 2, 3 or 4 stages.
- R7: A loaded DEN below 2 forces integer mode and a numerator of 0.
- R8: A loaded NUM at or above DEN (DEN at least 2) is replaced by DEN-1.
- R9: The dither source is a 23-bit shift register seeded with 1 by reset and not touched by load. On each non-load edge with `dither_en` high it shifts left, taking bit 22 XOR bit 17 into bit 0. Its bit 0, as it stands before that shift, is added to stage 1's input when `dither_en` is high; `dither_en` acts immediately and is not latched.
- R10: When the latched integer plus the offset is negative, `div_out` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Phase-detector rate clock |
| rst | input | 1 | Synchronous active-high reset |
| load | input | 1 | Take a new configuration and restart the modulator |
| int_in | input | INT_W | Integer part of the division value |
| num_in | input | FRAC_W | Fraction numerator |
| den_in | input | FRAC_W | Fraction modulus |
| order_in | input | 2 | 0 integer, 1 second, 2 third, 3 fourth order |
| dither_en | input | 1 | Add the pseudo-random bit to the first stage |
| div_out | output | INT_W+1 | Registered division value for the current cycle |

## Verification
The bound checker watches, every cycle, that residues stay below the modulus and that the latched numerator is below it. It also checks that the combined offset stays inside the span for the active order, that a load drives the raw integer to the output, that integer mode holds the output on the integer part, and that negative sums give zero. Exact carry sequences, the long-run mean, the dither contribution and the clamping of odd configurations can only be seen in the bench's scenarios. There a cycle-level model built from the requirements is compared with the output after every edge, and windowed sums are checked against the ideal fraction.

// File: rtl/fracn_pkg.sv
package fracn_pkg;

  // Number of cascaded first-order stages (fourth order at most).
  localparam int NSTAGE = 4;

  // Order select encoding on the configuration port.
  typedef enum logic [1:0] {
    ORD_INT = 2'd0,
    ORD_2ND = 2'd1,
    ORD_3RD = 2'd2,
    ORD_4TH = 2'd3
  } order_e;

  // Binomial coefficient used by the difference networks.
  function automatic int binom(input int n, input int k);
    int r;
    r = 1;
    for (int i = 0; i < k; i++) begin
      r = r * (n - i) / (i + 1);
    end
    return r;
  endfunction

  // Active stage count for an order code.
  function automatic logic [2:0] stages_for(input order_e o);
    case (o)
      ORD_2ND: return 3'd2;
      ORD_3RD: return 3'd3;
      ORD_4TH: return 3'd4;
      default: return 3'd0;
    endcase
  endfunction

endpackage

// File: rtl/fracn_lfsr.sv
module fracn_lfsr #(
  parameter int W   = 23,
  parameter int TAP = 18
) (
  input  logic clk,
  input  logic rst,
  input  logic adv,
  output logic bit_o
);

  logic [W-1:0] state_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= W'(1);
    end else if (adv) begin
      state_q <= {state_q[W-2:0], state_q[W-1] ^ state_q[TAP-1]};
    end
  end

  assign bit_o = state_q[0];

endmodule

// File: rtl/fracn_accum.sv
module fracn_accum #(
  parameter int AW = 23
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic [AW-1:0] den,
  input  logic [AW-1:0] add,
  output logic [AW-1:0] res,
  output logic          carry,
  output logic [AW-1:0] acc_q
);

  logic [AW:0] sum;

  always_comb begin
    sum   = {1'b0, acc_q} + {1'b0, add};
    carry = (sum >= {1'b0, den});
    res   = carry ? AW'(sum - {1'b0, den}) : AW'(sum);
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      acc_q <= '0;
    end else begin
      acc_q <= res;
    end
  end

endmodule

// File: rtl/fracn_combine.sv
module fracn_combine
  import fracn_pkg::*;
#(
  parameter int NS    = NSTAGE,
  parameter int OFF_W = NS + 1
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    clr,
  input  logic [NS-1:0]           carries,
  output logic signed [OFF_W-1:0] offset
);

  logic signed [OFF_W-1:0] terms [NS];

  assign terms[0] = OFF_W'(carries[0]);

  for (genvar k = 1; k < NS; k++) begin : g_diff
    logic [k-1:0]            hist_q;
    logic [k:0]              win;
    logic signed [OFF_W-1:0] tv;

    assign win = {hist_q, carries[k]};

    always_ff @(posedge clk) begin
      if (rst || clr) begin
        hist_q <= '0;
      end else begin
        hist_q <= win[k-1:0];
      end
    end

    always_comb begin
      tv = '0;
      for (int j = 0; j <= k; j++) begin
        if (win[j]) begin
          if (j % 2 == 1) tv = tv - OFF_W'(binom(k, j));
          else            tv = tv + OFF_W'(binom(k, j));
        end
      end
    end

    assign terms[k] = tv;
  end

  always_comb begin
    offset = '0;
    for (int k = 0; k < NS; k++) begin
      offset = offset + terms[k];
    end
  end

endmodule

// File: rtl/fracn_shaper.sv
module fracn_shaper
  import fracn_pkg::*;
#(
  parameter int INT_W    = 10,
  parameter int FRAC_W   = 22,
  parameter int LFSR_W   = 23,
  parameter int LFSR_TAP = 18
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [INT_W-1:0]  int_in,
  input  logic [FRAC_W-1:0] num_in,
  input  logic [FRAC_W-1:0] den_in,
  input  logic [1:0]        order_in,
  input  logic              dither_en,
  output logic [INT_W:0]    div_out
);

  localparam int AW    = FRAC_W + 1;
  localparam int OFF_W = NSTAGE + 1;
  localparam int SUM_W = INT_W + 2;
  localparam int OUT_W = INT_W + 1;

  logic [INT_W-1:0]  cfg_int;
  logic [FRAC_W-1:0] cfg_num;
  logic [FRAC_W-1:0] cfg_den;
  logic [2:0]        cfg_nst;

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_int <= '0;
      cfg_num <= '0;
      cfg_den <= '0;
      cfg_nst <= '0;
    end else if (load) begin
      cfg_int <= int_in;
      cfg_den <= den_in;
      if (den_in < FRAC_W'(2)) begin
        cfg_num <= '0;
        cfg_nst <= '0;
      end else begin
        cfg_num <= (num_in >= den_in) ? den_in - FRAC_W'(1) : num_in;
        cfg_nst <= stages_for(order_e'(order_in));
      end
    end
  end

  logic dith_bit;

  fracn_lfsr #(.W(LFSR_W), .TAP(LFSR_TAP)) u_lfsr (
    .clk  (clk),
    .rst  (rst),
    .adv  (dither_en && !load),
    .bit_o(dith_bit)
  );

  logic [NSTAGE-1:0][AW-1:0] stage_in;
  logic [NSTAGE-1:0][AW-1:0] stage_res;
  logic [NSTAGE-1:0][AW-1:0] acc_all;
  logic [NSTAGE-1:0]         carry_raw;
  logic [NSTAGE-1:0]         carry_m;

  assign stage_in[0] = AW'(cfg_num) + AW'(dith_bit & dither_en);

  for (genvar k = 0; k < NSTAGE; k++) begin : g_stage
    if (k > 0) begin : g_link
      assign stage_in[k] = stage_res[k-1];
    end

    fracn_accum #(.AW(AW)) u_acc (
      .clk  (clk),
      .rst  (rst),
      .clr  (load),
      .den  (AW'(cfg_den)),
      .add  (stage_in[k]),
      .res  (stage_res[k]),
      .carry(carry_raw[k]),
      .acc_q(acc_all[k])
    );

    assign carry_m[k] = carry_raw[k] & (3'(k) < cfg_nst);
  end

  logic signed [OFF_W-1:0] offset;

  fracn_combine #(.NS(NSTAGE), .OFF_W(OFF_W)) u_comb (
    .clk    (clk),
    .rst    (rst),
    .clr    (load),
    .carries(carry_m),
    .offset (offset)
  );

  logic signed [SUM_W-1:0] total;

  assign total = $signed({2'b00, cfg_int}) +
                 $signed({{(SUM_W-OFF_W){offset[OFF_W-1]}}, offset});

  always_ff @(posedge clk) begin
    if (rst) begin
      div_out <= '0;
    end else if (load) begin
      div_out <= {1'b0, int_in};
    end else if (total < 0) begin
      div_out <= '0;
    end else begin
      div_out <= OUT_W'(total);
    end
  end

endmodule

// File: rtl/fracn_shaper_chk.sv
module fracn_shaper_chk
  import fracn_pkg::*;
#(
  parameter int INT_W  = 10,
  parameter int FRAC_W = 22
) (
  input logic                          clk,
  input logic                          rst,
  input logic                          load,
  input logic [INT_W-1:0]              int_in,
  input logic [INT_W:0]                div_out,
  input logic [INT_W-1:0]              cfg_int,
  input logic [FRAC_W-1:0]             cfg_num,
  input logic [FRAC_W-1:0]             cfg_den,
  input logic [2:0]                    cfg_nst,
  input logic signed [NSTAGE:0]        offset,
  input logic [NSTAGE-1:0][FRAC_W:0]   acc_all
);

  logic signed [INT_W+1:0] ideal;
  assign ideal = $signed({2'b00, cfg_int}) +
                 $signed({{(INT_W+1-NSTAGE){offset[NSTAGE]}}, offset});

  AST_LOAD_INT: assert property (@(posedge clk) disable iff (rst)
    load |=> (div_out == {1'b0, $past(int_in)})) else $error("load value"); // R2

  AST_INT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!load && cfg_nst == 3'd0) |=> (div_out == {1'b0, $past(cfg_int)})) else $error("integer hold"); // R3

  AST_NUM_CLAMP: assert property (@(posedge clk) disable iff (rst)
    (cfg_den >= FRAC_W'(2)) |-> (cfg_num < cfg_den)) else $error("numerator clamp"); // R8

  AST_OFFSET_SPAN: assert property (@(posedge clk) disable iff (rst)
    (cfg_nst == 3'd0) ? (offset == 0)
      : ((int'(offset) <= (1 <<< (int'(cfg_nst) - 1))) &&
         (int'(offset) >= 1 - (1 <<< (int'(cfg_nst) - 1))))) else $error("offset span"); // R5

  AST_SAT_ZERO: assert property (@(posedge clk) disable iff (rst)
    (!load && ideal < 0) |=> (div_out == '0)) else $error("saturation"); // R10

  for (genvar k = 0; k < NSTAGE; k++) begin : g_res
    AST_RESIDUE_BELOW: assert property (@(posedge clk) disable iff (rst)
      (cfg_den >= FRAC_W'(2)) |-> (acc_all[k] < {1'b0, cfg_den})) else $error("residue"); // R4
  end

endmodule

bind fracn_shaper fracn_shaper_chk #(.INT_W(INT_W), .FRAC_W(FRAC_W)) u_chk (
  .clk    (clk),
  .rst    (rst),
  .load   (load),
  .int_in (int_in),
  .div_out(div_out),
  .cfg_int(cfg_int),
  .cfg_num(cfg_num),
  .cfg_den(cfg_den),
  .cfg_nst(cfg_nst),
  .offset (offset),
  .acc_all(acc_all)
);

// File: tb/tb_fracn_shaper.sv
`timescale 1ns/1ps
module tb_fracn_shaper;

  localparam int INT_W  = 10;
  localparam int FRAC_W = 22;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              load = 1'b0;
  logic [INT_W-1:0]  int_in = '0;
  logic [FRAC_W-1:0] num_in = '0;
  logic [FRAC_W-1:0] den_in = '0;
  logic [1:0]        order_in = '0;
  logic              dither_en = 1'b0;
  logic [INT_W:0]    div_out;

  always #2 clk = ~clk;

  fracn_shaper #(.INT_W(INT_W), .FRAC_W(FRAC_W)) dut (
    .clk(clk), .rst(rst), .load(load), .int_in(int_in), .num_in(num_in),
    .den_in(den_in), .order_in(order_in), .dither_en(dither_en), .div_out(div_out)
  );

  // Cycle model written from the requirements.
  logic [22:0] m_lfsr;
  longint m_acc [4];
  int     m_h [4][3];
  int     m_c [4];
  longint m_in, m_s;
  int     m_y, m_t, m_out, m_int, m_nst;
  longint m_num, m_den;

  always @(posedge clk) begin
    if (rst) begin
      m_lfsr = 23'd1; m_out = 0; m_int = 0; m_den = 0; m_num = 0; m_nst = 0;
      for (int k = 0; k < 4; k++) begin
        m_acc[k] = 0;
        for (int j = 0; j < 3; j++) m_h[k][j] = 0;
      end
    end else if (load) begin
      m_int = int'(int_in); m_den = longint'(den_in);
      if (den_in < 2) begin m_num = 0; m_nst = 0; end
      else begin
        m_num = (num_in >= den_in) ? m_den - 1 : longint'(num_in);
        m_nst = (order_in == 0) ? 0 : int'(order_in) + 1;
      end
      for (int k = 0; k < 4; k++) begin
        m_acc[k] = 0;
        for (int j = 0; j < 3; j++) m_h[k][j] = 0;
      end
      m_out = int'(int_in);
    end else begin
      m_in = m_num + ((dither_en && m_lfsr[0]) ? 1 : 0);
      for (int k = 0; k < 4; k++) begin
        m_s = m_acc[k] + m_in;
        m_c[k] = (m_s >= m_den) ? 1 : 0;
        if (m_c[k] == 1) m_s = m_s - m_den;
        m_acc[k] = m_s & 64'h7F_FFFF;
        m_in = m_acc[k];
        if (k >= m_nst) m_c[k] = 0;
      end
      m_y = m_c[0] + (m_c[1] - m_h[1][0]) + (m_c[2] - 2*m_h[2][0] + m_h[2][1])
          + (m_c[3] - 3*m_h[3][0] + 3*m_h[3][1] - m_h[3][2]);
      for (int k = 0; k < 4; k++) begin
        m_h[k][2] = m_h[k][1]; m_h[k][1] = m_h[k][0]; m_h[k][0] = m_c[k];
      end
      m_t = m_int + m_y;
      m_out = (m_t < 0) ? 0 : m_t;
      if (dither_en) m_lfsr = {m_lfsr[21:0], m_lfsr[22] ^ m_lfsr[17]};
    end
  end

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  task automatic check_val(input string tag, input int act, input int exp_v);
    n_chk++;
    if (act != exp_v) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp_v, $time);
    end
  endtask

  task automatic tick(input string tag);
    @(posedge clk);
    @(negedge clk);
    check_val(tag, int'(div_out), m_out);
  endtask

  typedef struct packed {
    logic [9:0]  ip;
    logic [21:0] num;
    logic [21:0] den;
    logic [1:0]  ord;
    logic        dith;
    logic [15:0] cyc;
  } vec_t;

  localparam vec_t VEC [10] = '{
    '{10'd100, 22'd3,       22'd10,      2'd1, 1'b0, 16'd200},
    '{10'd100, 22'd61,      22'd100,     2'd2, 1'b0, 16'd300},
    '{10'd173, 22'd1,       22'd3,       2'd3, 1'b0, 16'd300},
    '{10'd50,  22'd4194302, 22'd4194303, 2'd3, 1'b0, 16'd400},
    '{10'd80,  22'd0,       22'd7,       2'd3, 1'b0, 16'd100},
    '{10'd64,  22'd5,       22'd12,      2'd2, 1'b1, 16'd300},
    '{10'd30,  22'd9,       22'd10,      2'd0, 1'b0, 16'd50},
    '{10'd30,  22'd500,     22'd9,       2'd1, 1'b0, 16'd100},
    '{10'd40,  22'd5,       22'd1,       2'd3, 1'b0, 16'd50},
    '{10'd3,   22'd7,       22'd16,      2'd3, 1'b0, 16'd300}
  };

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    string  tag;
    longint msum, ideal;
    int     lo, hi;

    repeat (3) @(negedge clk);
    check_val("R1 reset", int'(div_out), 0);
    rst = 1'b0;
    for (int i = 0; i < 4; i++) tick("R1 idle");

    foreach (VEC[v]) begin
      if (VEC[v].dith)           tag = "R9";
      else if (VEC[v].den < 2)   tag = "R7";
      else if (VEC[v].num >= VEC[v].den) tag = "R8";
      else if (VEC[v].ord == 0)  tag = "R3";
      else if (VEC[v].ip < 8)    tag = "R10";
      else                       tag = "R4/R5";
      int_in = VEC[v].ip; num_in = VEC[v].num; den_in = VEC[v].den;
      order_in = VEC[v].ord; dither_en = VEC[v].dith; load = 1'b1;
      tick("R2 load");
      check_val("R2 load value", int'(div_out), int'(VEC[v].ip));
      load = 1'b0;
      num_in = 22'd1; den_in = 22'd5; int_in = 10'd7;  // ignored until next load
      msum = 0;
      for (int c = 0; c < int'(VEC[v].cyc); c++) begin
        tick(tag);
        msum += longint'(div_out) - longint'(VEC[v].ip);
      end
      if (!VEC[v].dith && VEC[v].ip >= 8) begin
        ideal = (m_nst == 0) ? 0 : (longint'(VEC[v].cyc) * m_num) / m_den;
        case (m_nst)
          2: begin lo = 0;  hi = 1; end
          3: begin lo = -1; hi = 2; end
          4: begin lo = -3; hi = 4; end
          default: begin lo = 0; hi = 0; end
        endcase
        n_chk++;
        if (msum - ideal < lo || msum - ideal > hi) begin
          n_fail++;
          $display("FAIL R6 mean: actual %0d expected %0d (+%0d..%0d)", msum, ideal, lo, hi);
        end
      end
      dither_en = 1'b0;
    end

    // R2: reloading the same setting must repeat the same sequence
    int_in = 10'd120; num_in = 22'd7; den_in = 22'd23; order_in = 2'd3; load = 1'b1;
    tick("R2 reload");
    load = 1'b0;
    for (int c = 0; c < 37; c++) tick("R2 run");
    load = 1'b1;
    tick("R2 reload again");
    load = 1'b0;
    for (int c = 0; c < 60; c++) tick("R2 restart");

    // R1: reset in the middle of a run
    rst = 1'b1;
    @(posedge clk); @(negedge clk);
    check_val("R1 mid reset", int'(div_out), 0);
    rst = 1'b0;
    for (int i = 0; i < 5; i++) tick("R1 after reset");

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule